// File: doc/BRIEF.md
# Direct-Mapped Translation Fast-Path Gate

This block sits between an address generator and a slow translation engine. For each access it receives a linear address, a size, a kind (read, write or read-for-modify) and the current privilege level. It looks the access up in a small direct-mapped cache of page translations and decides whether the access can go straight to a host address or must be handed to the slow path.

Each cache entry holds a linear page tag, a host page number, a four-bit permission mask and a physical page number. A table of write stamps, one counter per physical page, gates every write-class hit: a stamp of zero refuses the fast path, and each write-class hit decrements the stamp by one. This lets code-write tracking logic see how many fast writes a page has taken. Entries are loaded through a plain refill port and stamps through a stamp-load port. The outcome of a request appears one clock after it is presented, as a one-cycle hit pulse with the host address or as a one-cycle miss pulse that carries the request to the slow path.

Top module: `xfp_gate`

## Requirements
- R1: After reset, hit_valid, miss_valid and rmw_addr are zero, every entry is invalid and every stamp is zero, so the first request of any kind misses.
- R2: The entry is selected by linear address bits [12+IDX_W-1:12] and hits only when it is valid and its stored tag equals linear address bits [31:12]; an entry with the same index and a different tag misses.
- R3: Size codes are 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. The fast path requires the page offset (bits [11:0]) to be at most 0xFFE for 2 bytes, 0xFFC for 4 bytes and 0xFF8 for 8 bytes; 1-byte accesses always qualify; otherwise the request misses.
- R4: The privilege bit is 1 when req_cpl is 3 and 0 for levels 0, 1 and 2; miss_pl carries it.
- R5: Kind codes are 0=read, 1=write, 2=read-for-modify, 3=treated as write. A read hit needs mask bit [pl] set (bit 0 supervisor read, bit 1 user read).
- R6: A write or read-for-modify hit needs mask bit [2+pl] set (bit 2 supervisor write, bit 3 user write).
- R7: An entry whose host page number is zero never hits, whatever its tag and mask.
- R8: A write-class hit additionally needs a nonzero stamp for the entry's physical page and decrements that stamp by one; refused requests leave the stamp unchanged.
- R9: A hit raises hit_valid for one cycle, one clock after the request, with hit_haddr = {host page, page offset}.
- R10: A miss raises miss_valid for one cycle, one clock after the request, carrying the linear address, size code, privilege bit and kind; with no request both pulses stay low.
- R11: A read-for-modify hit stores its host address in rmw_addr, which holds until the next read-for-modify hit; other hits and misses leave it unchanged.
- R12: A refill or stamp load in the same cycle as a request takes effect after it: the request sees the old entry and old stamp, and a stamp load overrides a decrement of the same page in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_laddr | input | 32 | Linear address of the access |
| req_len | input | 2 | Size code (1, 2, 4, 8 bytes) |
| req_kind | input | 2 | Access kind code |
| req_cpl | input | 2 | Current privilege level |
| fill_valid | input | 1 | Write one cache entry |
| fill_vpage | input | 20 | Linear page number of the new entry (index and tag) |
| fill_hpage | input | 20 | Host page number of the new entry |
| fill_mask | input | 4 | Permission mask of the new entry |
| fill_ppn | input | PPN_W | Physical page number of the new entry |
| stamp_load | input | 1 | Write one stamp |
| stamp_ppn | input | PPN_W | Physical page whose stamp is written |
| stamp_val | input | STAMP_W | New stamp value |
| hit_valid | output | 1 | One-cycle fast-path hit pulse |
| hit_haddr | output | 32 | Host address of the hit |
| miss_valid | output | 1 | One-cycle slow-path request pulse |
| miss_laddr | output | 32 | Linear address of the miss |
| miss_len | output | 2 | Size code of the miss |
| miss_kind | output | 2 | Kind code of the miss |
| miss_pl | output | 1 | Privilege bit of the miss |
| rmw_addr | output | 32 | Host address recorded by the last read-for-modify hit |

## Verification
The hardest condition to reach is a stamp load and a stamp-decrementing write hit landing on the same physical page in the same cycle, since the stamp is never visible at the ports. The bench arms a page with stamp 1, presents the write and a load of 5 together, and then counts how many further writes hit before the first miss: exactly five proves the load won and the old stamp gated the simultaneous write. The same counting approach, and a refill issued alongside a request to its own index, exposes the otherwise hidden entry and stamp state.

// File: rtl/xfp_pkg.sv
package xfp_pkg;

    localparam int LADDR_W = 32;
    localparam int OFF_W   = 12;
    localparam int VPN_W   = LADDR_W - OFF_W;
    localparam int HPN_W   = 20;
    localparam int HADDR_W = HPN_W + OFF_W;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_RMW   = 2'd2,
        KIND_RSVD  = 2'd3
    } xfp_kind_e;

    typedef enum logic [1:0] {
        SZ_1 = 2'd0,
        SZ_2 = 2'd1,
        SZ_4 = 2'd2,
        SZ_8 = 2'd3
    } xfp_size_e;

    // True when an access of the given size starting at off stays in its page.
    function automatic logic fits_page(input logic [OFF_W-1:0] off, input logic [1:0] sz);
        logic ok;
        case (xfp_size_e'(sz))
            SZ_1:    ok = 1'b1;
            SZ_2:    ok = (off <= 12'hFFE);
            SZ_4:    ok = (off <= 12'hFFC);
            default: ok = (off <= 12'hFF8);
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/xfp_entry_bank.sv
module xfp_entry_bank #(
    parameter int IDX_W = 4,
    parameter int PPN_W = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [xfp_pkg::VPN_W-1:0] wr_vpn,
    input  logic [xfp_pkg::HPN_W-1:0] wr_hpn,
    input  logic [3:0]                wr_mask,
    input  logic [PPN_W-1:0]          wr_ppn,
    input  logic [IDX_W-1:0]          rd_idx,
    output logic                      rd_valid,
    output logic [xfp_pkg::VPN_W-1:0] rd_vpn,
    output logic [xfp_pkg::HPN_W-1:0] rd_hpn,
    output logic [3:0]                rd_mask,
    output logic [PPN_W-1:0]          rd_ppn
);
    import xfp_pkg::*;

    localparam int NENT = 1 << IDX_W;

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [HPN_W-1:0] hpn;
        logic [3:0]       mask;
        logic [PPN_W-1:0] ppn;
    } ent_t;

    ent_t ent_all [NENT];

    logic [IDX_W-1:0] wr_idx;
    assign wr_idx = wr_vpn[IDX_W-1:0];

    for (genvar e = 0; e < NENT; e++) begin : g_ent
        ent_t ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_en && (wr_idx == IDX_W'(e))) begin
                ent_d.valid = 1'b1;
                ent_d.vpn   = wr_vpn;
                ent_d.hpn   = wr_hpn;
                ent_d.mask  = wr_mask;
                ent_d.ppn   = wr_ppn;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end

        assign ent_all[e] = ent_q;
    end

    ent_t rd_ent;
    assign rd_ent   = ent_all[rd_idx];
    assign rd_valid = rd_ent.valid;
    assign rd_vpn   = rd_ent.vpn;
    assign rd_hpn   = rd_ent.hpn;
    assign rd_mask  = rd_ent.mask;
    assign rd_ppn   = rd_ent.ppn;

endmodule

// File: rtl/xfp_stamp_bank.sv
module xfp_stamp_bank #(
    parameter int PPN_W   = 6,
    parameter int STAMP_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PPN_W-1:0]   rd_ppn,
    output logic [STAMP_W-1:0] rd_stamp,
    input  logic               dec_en,
    input  logic [PPN_W-1:0]   dec_ppn,
    input  logic               ld_en,
    input  logic [PPN_W-1:0]   ld_ppn,
    input  logic [STAMP_W-1:0] ld_val
);
    localparam int NPAGE = 1 << PPN_W;

    logic [STAMP_W-1:0] stamp_d [NPAGE];
    logic [STAMP_W-1:0] stamp_q [NPAGE];

    always_comb begin
        for (int p = 0; p < NPAGE; p++) stamp_d[p] = stamp_q[p];
        if (dec_en) stamp_d[dec_ppn] = stamp_q[dec_ppn] - STAMP_W'(1);
        // A load issued in the same cycle is applied last and wins.
        if (ld_en)  stamp_d[ld_ppn]  = ld_val;
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < NPAGE; p++) begin
            if (!rst_n) stamp_q[p] <= '0;
            else        stamp_q[p] <= stamp_d[p];
        end
    end

    assign rd_stamp = stamp_q[rd_ppn];

endmodule

// File: rtl/xfp_gate.sv
module xfp_gate #(
    parameter int IDX_W   = 4,
    parameter int PPN_W   = 6,
    parameter int STAMP_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [31:0]        req_laddr,
    input  logic [1:0]         req_len,
    input  logic [1:0]         req_kind,
    input  logic [1:0]         req_cpl,
    input  logic               fill_valid,
    input  logic [19:0]        fill_vpage,
    input  logic [19:0]        fill_hpage,
    input  logic [3:0]         fill_mask,
    input  logic [PPN_W-1:0]   fill_ppn,
    input  logic               stamp_load,
    input  logic [PPN_W-1:0]   stamp_ppn,
    input  logic [STAMP_W-1:0] stamp_val,
    output logic               hit_valid,
    output logic [31:0]        hit_haddr,
    output logic               miss_valid,
    output logic [31:0]        miss_laddr,
    output logic [1:0]         miss_len,
    output logic [1:0]         miss_kind,
    output logic               miss_pl,
    output logic [31:0]        rmw_addr
);
    import xfp_pkg::*;

    typedef struct packed {
        logic               hit;
        logic [HADDR_W-1:0] haddr;
        logic               miss;
        logic [LADDR_W-1:0] m_laddr;
        logic [1:0]         m_len;
        logic [1:0]         m_kind;
        logic               m_pl;
        logic [HADDR_W-1:0] rmw;
    } out_t;

    out_t out_d, out_q;

    // Request decode
    logic [OFF_W-1:0] req_off;
    logic [VPN_W-1:0] req_vpn;
    logic [IDX_W-1:0] req_idx;
    logic             pl;
    logic             is_wr;
    assign req_off = req_laddr[OFF_W-1:0];
    assign req_vpn = req_laddr[LADDR_W-1:OFF_W];
    assign req_idx = req_vpn[IDX_W-1:0];
    assign pl      = (req_cpl == 2'd3);
    assign is_wr   = (xfp_kind_e'(req_kind) != KIND_READ);

    // Entry lookup
    logic             e_valid;
    logic [VPN_W-1:0] e_vpn;
    logic [HPN_W-1:0] e_hpn;
    logic [3:0]       e_mask;
    logic [PPN_W-1:0] e_ppn;

    xfp_entry_bank #(.IDX_W(IDX_W), .PPN_W(PPN_W)) u_entries (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (fill_valid),
        .wr_vpn   (fill_vpage),
        .wr_hpn   (fill_hpage),
        .wr_mask  (fill_mask),
        .wr_ppn   (fill_ppn),
        .rd_idx   (req_idx),
        .rd_valid (e_valid),
        .rd_vpn   (e_vpn),
        .rd_hpn   (e_hpn),
        .rd_mask  (e_mask),
        .rd_ppn   (e_ppn)
    );

    // Write stamps
    logic [STAMP_W-1:0] cur_stamp;
    logic               dec_en;

    xfp_stamp_bank #(.PPN_W(PPN_W), .STAMP_W(STAMP_W)) u_stamps (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_ppn   (e_ppn),
        .rd_stamp (cur_stamp),
        .dec_en   (dec_en),
        .dec_ppn  (e_ppn),
        .ld_en    (stamp_load),
        .ld_ppn   (stamp_ppn),
        .ld_val   (stamp_val)
    );

    // Fast-path decision
    logic tag_ok, in_page, perm_ok, host_ok, stamp_ok, fast;

    always_comb begin
        tag_ok   = e_valid && (e_vpn == req_vpn);
        in_page  = fits_page(req_off, req_len);
        perm_ok  = e_mask[{is_wr, pl}];
        host_ok  = (e_hpn != '0);
        stamp_ok = !is_wr || (cur_stamp != '0);
        fast     = tag_ok && in_page && perm_ok && host_ok && stamp_ok;
        dec_en   = req_valid && fast && is_wr;
    end

    always_comb begin
        out_d      = out_q;
        out_d.hit  = req_valid && fast;
        out_d.miss = req_valid && !fast;
        if (req_valid && fast) begin
            out_d.haddr = {e_hpn, req_off};
            if (xfp_kind_e'(req_kind) == KIND_RMW) out_d.rmw = {e_hpn, req_off};
        end
        if (req_valid && !fast) begin
            out_d.m_laddr = req_laddr;
            out_d.m_len   = req_len;
            out_d.m_kind  = req_kind;
            out_d.m_pl    = pl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign hit_valid  = out_q.hit;
    assign hit_haddr  = out_q.haddr;
    assign miss_valid = out_q.miss;
    assign miss_laddr = out_q.m_laddr;
    assign miss_len   = out_q.m_len;
    assign miss_kind  = out_q.m_kind;
    assign miss_pl    = out_q.m_pl;
    assign rmw_addr   = out_q.rmw;

endmodule

// File: rtl/xfp_gate_chk.sv
module xfp_gate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_laddr,
    input logic [1:0]  req_len,
    input logic [1:0]  req_kind,
    input logic [1:0]  req_cpl,
    input logic        hit_valid,
    input logic        miss_valid,
    input logic [31:0] miss_laddr,
    input logic        miss_pl,
    input logic [31:0] rmw_addr
);
    import xfp_pkg::*;

    // R10
    exclusive_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_valid && miss_valid));

    // R10
    one_outcome_per_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (hit_valid || miss_valid));

    // R10
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!hit_valid && !miss_valid));

    // R10
    miss_carries_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!miss_valid || miss_laddr == $past(req_laddr)));

    // R4
    miss_pl_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!miss_valid || miss_pl == ($past(req_cpl) == 2'd3)));

    // R3
    no_cross_page_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !fits_page(req_laddr[11:0], req_len)) |=> !hit_valid);

    // R11
    rmw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || req_kind != 2'd2) |=> $stable(rmw_addr));

endmodule

bind xfp_gate xfp_gate_chk u_gate_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_laddr  (req_laddr),
    .req_len    (req_len),
    .req_kind   (req_kind),
    .req_cpl    (req_cpl),
    .hit_valid  (hit_valid),
    .miss_valid (miss_valid),
    .miss_laddr (miss_laddr),
    .miss_pl    (miss_pl),
    .rmw_addr   (rmw_addr)
);

// File: tb/tb_xfp_gate.sv
module tb_xfp_gate;
    localparam int CLK_PERIOD = 10;
    localparam int PPN_W      = 6;
    localparam int STAMP_W    = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic [31:0]        req_laddr = '0;
    logic [1:0]         req_len = '0;
    logic [1:0]         req_kind = '0;
    logic [1:0]         req_cpl = '0;
    logic               fill_valid = 1'b0;
    logic [19:0]        fill_vpage = '0;
    logic [19:0]        fill_hpage = '0;
    logic [3:0]         fill_mask = '0;
    logic [PPN_W-1:0]   fill_ppn = '0;
    logic               stamp_load = 1'b0;
    logic [PPN_W-1:0]   stamp_ppn = '0;
    logic [STAMP_W-1:0] stamp_val = '0;
    logic               hit_valid, miss_valid, miss_pl;
    logic [31:0]        hit_haddr, miss_laddr, rmw_addr;
    logic [1:0]         miss_len, miss_kind;

    int total = 0;
    int bad   = 0;

    // Values captured one cycle after each request
    logic        g_hit, g_miss, g_pl;
    logic [31:0] g_haddr, g_mladdr, g_rmw;
    logic [1:0]  g_mlen, g_mkind;

    xfp_gate #(.IDX_W(4), .PPN_W(PPN_W), .STAMP_W(STAMP_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_laddr(req_laddr), .req_len(req_len),
        .req_kind(req_kind), .req_cpl(req_cpl),
        .fill_valid(fill_valid), .fill_vpage(fill_vpage), .fill_hpage(fill_hpage),
        .fill_mask(fill_mask), .fill_ppn(fill_ppn),
        .stamp_load(stamp_load), .stamp_ppn(stamp_ppn), .stamp_val(stamp_val),
        .hit_valid(hit_valid), .hit_haddr(hit_haddr),
        .miss_valid(miss_valid), .miss_laddr(miss_laddr), .miss_len(miss_len),
        .miss_kind(miss_kind), .miss_pl(miss_pl), .rmw_addr(rmw_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic capture();
        g_hit = hit_valid; g_miss = miss_valid; g_haddr = hit_haddr;
        g_mladdr = miss_laddr; g_mlen = miss_len; g_mkind = miss_kind;
        g_pl = miss_pl; g_rmw = rmw_addr;
    endtask

    task automatic do_req(input logic [31:0] a, input logic [1:0] sz,
                          input logic [1:0] k, input logic [1:0] cpl);
        @(negedge clk);
        req_valid = 1'b1; req_laddr = a; req_len = sz; req_kind = k; req_cpl = cpl;
        @(negedge clk);
        capture();
        req_valid = 1'b0;
    endtask

    task automatic do_fill(input logic [19:0] vp, input logic [19:0] hp,
                           input logic [3:0] m, input logic [PPN_W-1:0] pp);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpage = vp; fill_hpage = hp; fill_mask = m; fill_ppn = pp;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic do_stamp(input logic [PPN_W-1:0] pp, input logic [STAMP_W-1:0] v);
        @(negedge clk);
        stamp_load = 1'b1; stamp_ppn = pp; stamp_val = v;
        @(negedge clk);
        stamp_load = 1'b0;
    endtask

    task automatic expect_hit(input string req, input logic [31:0] ha);
        check(req, {31'd0, g_hit}, 32'd1);
        check(req, g_haddr, ha);
    endtask

    task automatic expect_miss(input string req);
        check(req, {31'd0, g_miss}, 32'd1);
        check(req, {31'd0, g_hit}, 32'd0);
    endtask

    task automatic t_reset();
        check("R1 hit after reset", {31'd0, hit_valid}, 32'd0);
        check("R1 miss after reset", {31'd0, miss_valid}, 32'd0);
        check("R1 rmw_addr after reset", rmw_addr, 32'd0);
        do_req(32'h1234_5ABC, 2'd0, 2'd0, 2'd0);
        expect_miss("R1 empty cache");
        // R10 miss fields
        do_req(32'h0009_9FF0, 2'd3, 2'd1, 2'd3);
        expect_miss("R10 miss pulse");
        check("R10 miss laddr", g_mladdr, 32'h0009_9FF0);
        check("R10 miss len", {30'd0, g_mlen}, 32'd3);
        check("R10 miss kind", {30'd0, g_mkind}, 32'd1);
        check("R4 miss pl cpl3", {31'd0, g_pl}, 32'd1);
        @(negedge clk);
        check("R10 pulse ends", {30'd0, hit_valid, miss_valid}, 32'd0);
    endtask

    task automatic t_lookup();
        do_fill(20'h12345, 20'hABCDE, 4'b0011, 6'd3);
        do_req(32'h1234_5ABC, 2'd0, 2'd0, 2'd0);
        expect_hit("R9 read hit addr", 32'hABCD_EABC);
        do_req(32'h2234_5ABC, 2'd0, 2'd0, 2'd0);
        expect_miss("R2 tag alias at same index");
    endtask

    task automatic t_priv();
        do_fill(20'h00021, 20'h11111, 4'b0001, 6'd1);
        do_req(32'h0002_1010, 2'd0, 2'd0, 2'd3);
        expect_miss("R5 user read without bit1");
        check("R4 pl for cpl3", {31'd0, g_pl}, 32'd1);
        do_req(32'h0002_1010, 2'd0, 2'd0, 2'd2);
        expect_hit("R4 cpl2 is supervisor", 32'h1111_1010);
    endtask

    task automatic t_write();
        do_fill(20'h00032, 20'h22222, 4'b0100, 6'd4);
        do_stamp(6'd4, 8'd2);
        do_req(32'h0003_2008, 2'd2, 2'd1, 2'd0);
        expect_hit("R8 write hit 1", 32'h2222_2008);
        do_req(32'h0003_2008, 2'd2, 2'd1, 2'd0);
        expect_hit("R8 write hit 2", 32'h2222_2008);
        do_req(32'h0003_2008, 2'd2, 2'd1, 2'd0);
        expect_miss("R8 stamp exhausted");
        do_req(32'h0003_2008, 2'd0, 2'd0, 2'd0);
        expect_miss("R5 read without bit0");
        do_stamp(6'd4, 8'd1);
        do_req(32'h0003_2008, 2'd0, 2'd3, 2'd3);
        expect_miss("R6 user write without bit3");
        do_req(32'h0003_2008, 2'd0, 2'd1, 2'd1);
        expect_hit("R8 refused write kept stamp", 32'h2222_2008);
    endtask

    task automatic t_cross();
        do_fill(20'h00043, 20'h33333, 4'b1111, 6'd5);
        do_req(32'h0004_3FFF, 2'd0, 2'd0, 2'd0); expect_hit("R3 1B at FFF", 32'h3333_3FFF);
        do_req(32'h0004_3FFE, 2'd1, 2'd0, 2'd0); expect_hit("R3 2B at FFE", 32'h3333_3FFE);
        do_req(32'h0004_3FFF, 2'd1, 2'd0, 2'd0); expect_miss("R3 2B at FFF");
        do_req(32'h0004_3FFC, 2'd2, 2'd0, 2'd0); expect_hit("R3 4B at FFC", 32'h3333_3FFC);
        do_req(32'h0004_3FFD, 2'd2, 2'd0, 2'd0); expect_miss("R3 4B at FFD");
        do_req(32'h0004_3FF8, 2'd3, 2'd0, 2'd0); expect_hit("R3 8B at FF8", 32'h3333_3FF8);
        do_req(32'h0004_3FF9, 2'd3, 2'd0, 2'd0); expect_miss("R3 8B at FF9");
    endtask

    task automatic t_host_zero();
        do_fill(20'h00054, 20'h00000, 4'b1111, 6'd6);
        do_stamp(6'd6, 8'd9);
        do_req(32'h0005_4100, 2'd0, 2'd0, 2'd0);
        expect_miss("R7 host zero read");
        do_req(32'h0005_4100, 2'd0, 2'd1, 2'd0);
        expect_miss("R7 host zero write");
    endtask

    task automatic t_rmw();
        do_fill(20'h00066, 20'h44444, 4'b0100, 6'd7);
        do_stamp(6'd7, 8'd1);
        do_req(32'h0006_6123, 2'd1, 2'd2, 2'd0);
        expect_hit("R11 rmw hit", 32'h4444_4123);
        check("R11 rmw recorded", g_rmw, 32'h4444_4123);
        do_req(32'h0006_6123, 2'd1, 2'd2, 2'd0);
        expect_miss("R8 rmw consumed stamp");
        check("R11 rmw miss keeps record", g_rmw, 32'h4444_4123);
        do_req(32'h1234_5ABC, 2'd0, 2'd0, 2'd0);
        expect_hit("R11 plain read hit", 32'hABCD_EABC);
        check("R11 read hit keeps record", g_rmw, 32'h4444_4123);
    endtask

    task automatic t_collide();
        int n_hit;
        do_fill(20'h00077, 20'h55555, 4'b0011, 6'd8);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpage = 20'h00077; fill_hpage = 20'h66666;
        fill_mask = 4'b0011; fill_ppn = 6'd8;
        req_valid = 1'b1; req_laddr = 32'h0007_7040; req_len = 2'd0;
        req_kind = 2'd0; req_cpl = 2'd0;
        @(negedge clk);
        capture();
        fill_valid = 1'b0; req_valid = 1'b0;
        expect_hit("R12 request sees old entry", 32'h5555_5040);
        do_req(32'h0007_7040, 2'd0, 2'd0, 2'd0);
        expect_hit("R12 refill visible after", 32'h6666_6040);

        do_fill(20'h00077, 20'h66666, 4'b0100, 6'd9);
        do_stamp(6'd9, 8'd1);
        @(negedge clk);
        stamp_load = 1'b1; stamp_ppn = 6'd9; stamp_val = 8'd5;
        req_valid = 1'b1; req_laddr = 32'h0007_7040; req_len = 2'd0;
        req_kind = 2'd1; req_cpl = 2'd0;
        @(negedge clk);
        capture();
        stamp_load = 1'b0; req_valid = 1'b0;
        expect_hit("R12 write with old stamp", 32'h6666_6040);
        n_hit = 0;
        for (int i = 0; i < 7; i++) begin
            do_req(32'h0007_7040, 2'd0, 2'd1, 2'd0);
            if (g_hit) n_hit++;
        end
        check("R12 load wins over decrement", n_hit, 32'd5);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lookup();
        t_priv();
        t_write();
        t_cross();
        t_host_zero();
        t_rmw();
        t_collide();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule